// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the configuration of a clock synthesizer: a 9-bit feedback multiplier `M`, a 2-bit output divider code `N` and a 2-bit test selector `T`. Two independent load paths write the same set of registers. A parallel path takes `M` and `N` from pins under an active-low strobe; a three-wire serial path (data, clock, load) shifts a 13-bit frame into a staging register and moves it into the configuration under a separate load line. Each path has a transparent phase in which the configuration follows its source and a closing edge after which the configuration holds.

All control and data pins are asynchronous. They pass through a bank of two-flop synchronizers on the fast system clock, and the serial clock edge is found by an edge detector on that clock, so the system clock must run at least four times the serial clock rate and serial data must be stable around each serial clock edge. A diagnostic output picks one of four internal signals according to `T`, and is held low whenever the parallel path owns the configuration. A flag reports whether the current `M` lies in the range the loop can lock to.

Top module: `synth_cfg_loader`

## Requirements
- R1: After reset, `m_val`, `n_code` and `t_bits` are 0, `m_in_range` is 0 and `test_out` is 0.
- R2: While `par_load_n` is low, `m_val` and `n_code` follow `par_m` and `par_n` (within five system clocks of a pin change); `t_bits` is not changed by the parallel path.
- R3: When `par_load_n` rises, the last values are kept; later changes on `par_m`/`par_n` have no effect while `par_load_n` stays high and no serial load occurs.
- R4: While `par_load_n` is high, each rising `ser_clk` shifts `ser_data` into a 13-bit staging register; the frame order is T1, T0, N1, N0, M8 down to M0 (M0 last). Shifting alone, with `ser_load` low, leaves the configuration unchanged.
- R5: A rising `ser_load` (with `par_load_n` high) copies the staging register into the configuration; after `ser_load` falls, further shifts leave the configuration unchanged.
- R6: While `ser_load` stays high, every rising `ser_clk` updates the configuration with the newly shifted staging contents.
- R7: `test_out` by `t_bits`: 0 gives low, 1 gives the synchronized `ser_data`, 2 gives `mdiv_pulse`, 3 gives `half_rate`.
- R8: `test_out` is low from the moment `par_load_n` goes low until the next serial load; `t_bits` keeps its value across that time.
- R9: `m_in_range` is 1 exactly when `m_val` is between 10 and 28 inclusive, and updates with every load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| par_load_n | input | 1 | Parallel strobe, active low: transparent while low, latches on rise |
| par_m | input | 9 | Parallel multiplier value |
| par_n | input | 2 | Parallel output divider code |
| ser_clk | input | 1 | Serial shift clock, sampled on `clk` |
| ser_data | input | 1 | Serial data, sampled on rising `ser_clk` |
| ser_load | input | 1 | Serial load: transfer on rise, transparent while high, latch on fall |
| mdiv_pulse | input | 1 | Feedback divider output, diagnostic mux source |
| half_rate | input | 1 | Half-rate synthesizer output, diagnostic mux source |
| m_val | output | 9 | Active multiplier value |
| n_code | output | 2 | Active output divider code |
| t_bits | output | 2 | Active test selector |
| m_in_range | output | 1 | High when `m_val` is in the lockable range |
| test_out | output | 1 | Diagnostic output |

## Verification
The hardest state to reach from the ports is the transparent serial phase, where the load line is held high across several serial clocks and each shift must appear at once in the configuration, and its mirror, a shift after the load line falls that must change nothing. The bench reaches both by opening a frame load, holding `ser_load` high while clocking extra bits and tracking a model of the staging register, then dropping the line and shifting more bits. Mode hand-over between the two paths is driven by interleaving random parallel loads with random serial frames, so the diagnostic output is seen both forced low and released.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    localparam int M_W     = 9;
    localparam int N_W     = 2;
    localparam int T_W     = 2;
    localparam int FRAME_W = T_W + N_W + M_W;

    // Field order in the packed struct matches the serial frame:
    // T bits shifted first end up in the top bits.
    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_word_t;

    typedef enum logic [T_W-1:0] {
        TSEL_LOW   = 2'd0,
        TSEL_SDATA = 2'd1,
        TSEL_MDIV  = 2'd2,
        TSEL_HALF  = 2'd3
    } test_sel_e;

    function automatic logic m_lockable(input logic [M_W-1:0] m,
                                        input int lo, input int hi);
        return (int'(m) >= lo) && (int'(m) <= hi);
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
    import synth_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               sclk_s,
    input  logic               sdat_s,
    output logic [FRAME_W-1:0] sreg_nx
);
    logic               sclk_q;
    logic [FRAME_W-1:0] sreg_q;
    logic               shift_now;

    assign shift_now = en && sclk_s && !sclk_q;
    assign sreg_nx   = shift_now ? {sreg_q[FRAME_W-2:0], sdat_s} : sreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            sreg_q <= '0;
        end else begin
            sclk_q <= sclk_s;
            sreg_q <= sreg_nx;
        end
    end

    // R4: a detected serial clock edge lands the sampled bit in bit 0
    a_r4_shift_in: assert property (@(posedge clk) disable iff (rst)
        shift_now |=> (sreg_q[0] == $past(sdat_s)))
        else $error("a_r4_shift_in");

    // R4: no edge, no movement of the staging register
    a_r4_shift_idle: assert property (@(posedge clk) disable iff (rst)
        !shift_now |=> $stable(sreg_q))
        else $error("a_r4_shift_idle");
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import synth_cfg_pkg::*;
#(
    parameter int LOCK_MIN = 10,
    parameter int LOCK_MAX = 28
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pl_s,
    input  logic               sl_s,
    input  logic [M_W-1:0]     pm_s,
    input  logic [N_W-1:0]     pn_s,
    input  logic [FRAME_W-1:0] sreg_nx,
    output cfg_word_t          cfg_q,
    output logic               in_rng_q,
    output logic               par_mode_q
);
    cfg_word_t cfg_nx;
    logic      par_mode_nx;

    always_comb begin
        cfg_nx      = cfg_q;
        par_mode_nx = par_mode_q;
        if (!pl_s) begin
            cfg_nx.m    = pm_s;
            cfg_nx.n    = pn_s;
            par_mode_nx = 1'b1;
        end else if (sl_s) begin
            cfg_nx      = cfg_word_t'(sreg_nx);
            par_mode_nx = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            in_rng_q   <= 1'b0;
            par_mode_q <= 1'b1;
        end else begin
            cfg_q      <= cfg_nx;
            in_rng_q   <= m_lockable(cfg_nx.m, LOCK_MIN, LOCK_MAX);
            par_mode_q <= par_mode_nx;
        end
    end

    // R2: parallel transparency copies the synchronized pins, T untouched
    a_r2_par_follow: assert property (@(posedge clk) disable iff (rst)
        !pl_s |=> (cfg_q.m == $past(pm_s)) && (cfg_q.n == $past(pn_s)) && $stable(cfg_q.t))
        else $error("a_r2_par_follow");

    // R3/R5: with neither path open the configuration holds
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (pl_s && !sl_s) |=> $stable(cfg_q))
        else $error("a_r3_hold");

    // R9: range flag tracks the registered multiplier
    a_r9_range: assert property (@(posedge clk) disable iff (rst)
        in_rng_q == ((cfg_q.m >= M_W'(LOCK_MIN)) && (cfg_q.m <= M_W'(LOCK_MAX))))
        else $error("a_r9_range");
endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux
    import synth_cfg_pkg::*;
(
    input  logic [T_W-1:0] sel,
    input  logic           force_low,
    input  logic           sdat_s,
    input  logic           mdiv,
    input  logic           half,
    output logic           out
);
    always_comb begin
        unique case (test_sel_e'(sel))
            TSEL_SDATA: out = sdat_s;
            TSEL_MDIV:  out = mdiv;
            TSEL_HALF:  out = half;
            default:    out = 1'b0;
        endcase
        if (force_low) out = 1'b0;
    end

    // R7: selector zero never drives the output high
    always_comb begin
        a_r7_sel_low: assert (!(sel == TSEL_LOW && out)) else $error("a_r7_sel_low");
    end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_MIN    = 10,
    parameter int LOCK_MAX    = 28
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           par_load_n,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    input  logic           mdiv_pulse,
    input  logic           half_rate,
    output logic [M_W-1:0] m_val,
    output logic [N_W-1:0] n_code,
    output logic [T_W-1:0] t_bits,
    output logic           m_in_range,
    output logic           test_out
);
    localparam int SYNC_W = 4 + M_W + N_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, {(SYNC_W-1){1'b0}}};

    logic [SYNC_W-1:0]  raw_bus, syn_bus;
    logic               pl_s, sc_s, sd_s, sl_s;
    logic [M_W-1:0]     pm_s;
    logic [N_W-1:0]     pn_s;
    logic [FRAME_W-1:0] sreg_nx;
    cfg_word_t          cfg_q;
    logic               par_mode_q;

    assign raw_bus = {par_load_n, ser_clk, ser_data, ser_load, par_m, par_n};

    cfg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst(rst), .d(raw_bus), .q(syn_bus)
    );

    assign {pl_s, sc_s, sd_s, sl_s, pm_s, pn_s} = syn_bus;

    cfg_shift u_shift (
        .clk(clk), .rst(rst), .en(pl_s), .sclk_s(sc_s), .sdat_s(sd_s),
        .sreg_nx(sreg_nx)
    );

    cfg_regs #(.LOCK_MIN(LOCK_MIN), .LOCK_MAX(LOCK_MAX)) u_regs (
        .clk(clk), .rst(rst), .pl_s(pl_s), .sl_s(sl_s), .pm_s(pm_s), .pn_s(pn_s),
        .sreg_nx(sreg_nx), .cfg_q(cfg_q), .in_rng_q(m_in_range),
        .par_mode_q(par_mode_q)
    );

    cfg_test_mux u_mux (
        .sel(cfg_q.t), .force_low(par_mode_q), .sdat_s(sd_s),
        .mdiv(mdiv_pulse), .half(half_rate), .out(test_out)
    );

    assign m_val  = cfg_q.m;
    assign n_code = cfg_q.n;
    assign t_bits = cfg_q.t;

    // R8: parallel ownership keeps the diagnostic output low
    a_r8_par_low: assert property (@(posedge clk) disable iff (rst)
        par_mode_q |-> !test_out)
        else $error("a_r8_par_low");

    // R8: a low parallel strobe takes ownership on the next clock
    a_r8_take: assert property (@(posedge clk) disable iff (rst)
        !pl_s |=> par_mode_q)
        else $error("a_r8_take");
endmodule

// File: tb/sim_synth_cfg_loader.sv
`timescale 1ns/1ps
module sim_synth_cfg_loader;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       par_load_n = 1'b1;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic       mdiv_pulse = 1'b0, half_rate = 1'b0;
    logic [8:0] m_val;
    logic [1:0] n_code, t_bits;
    logic       m_in_range, test_out;

    int checks = 0, failures = 0;
    logic [12:0] e_sreg = '0;
    logic [8:0]  e_m = '0;
    logic [1:0]  e_n = '0, e_t = '0;
    logic        e_par = 1'b1;

    always #4 clk = ~clk;

    synth_cfg_loader u0 (.*);

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    function automatic logic e_range(input logic [8:0] m);
        return (m >= 9'd10) && (m <= 9'd28);
    endfunction

    function automatic logic e_test(input logic sd);
        if (e_par) return 1'b0;
        case (e_t)
            2'd1: return sd;
            2'd2: return mdiv_pulse;
            2'd3: return half_rate;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk_cfg(input string req);
        chk({req, " m"}, m_val, e_m);
        chk({req, " n"}, n_code, e_n);
        chk({req, " t"}, t_bits, e_t);
        chk({req, " range"}, m_in_range, e_range(e_m));
    endtask

    task automatic par_load(input logic [8:0] m, input logic [1:0] n);
        par_load_n = 1'b0; par_m = m; par_n = n;
        tick(5);
        e_m = m; e_n = n; e_par = 1'b1;
        par_load_n = 1'b1;
        tick(5);
    endtask

    task automatic ser_bit(input logic b);
        ser_data = b; tick(3);
        ser_clk = 1'b1; tick(3);
        ser_clk = 1'b0; tick(3);
        e_sreg = {e_sreg[11:0], b};
        if (ser_load) begin
            {e_t, e_n, e_m} = e_sreg; e_par = 1'b0;
        end
    endtask

    task automatic ser_frame(input logic [1:0] t, input logic [1:0] n, input logic [8:0] m);
        logic [12:0] f;
        f = {t, n, m};
        for (int i = 12; i >= 0; i--) ser_bit(f[i]);
        ser_load = 1'b1; tick(5);
        {e_t, e_n, e_m} = e_sreg; e_par = 1'b0;
        ser_load = 1'b0; tick(5);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        tick(4); rst = 1'b0; tick(4);
        // R1 reset state
        chk_cfg("R1");
        chk("R1 test", test_out, 0);

        // R2 transparent parallel path
        par_load_n = 1'b0; par_m = 9'd21; par_n = 2'd2; tick(5);
        chk("R2 m follow", m_val, 21); chk("R2 n follow", n_code, 2);
        par_m = 9'd300; par_n = 2'd1; tick(5);
        chk("R2 m follow2", m_val, 300); chk("R2 n follow2", n_code, 1);
        chk("R2 t untouched", t_bits, 0);
        par_load_n = 1'b1; tick(5);
        e_m = 9'd300; e_n = 2'd1;
        // R3 latched: pin changes ignored
        par_m = 9'd5; par_n = 2'd3; tick(6);
        chk_cfg("R3 hold");

        // R4 shifting alone changes nothing
        for (int i = 0; i < 7; i++) ser_bit(1'(i));
        chk_cfg("R4 shift only");

        // R5 frame load, order T1 T0 N1 N0 M8..M0
        ser_frame(2'd2, 2'd3, 9'd27);
        chk("R5 m", m_val, 27); chk("R5 n", n_code, 3); chk("R5 t", t_bits, 2);
        chk("R9 27 in range", m_in_range, 1);
        // R5 after fall, more shifts ignored
        ser_bit(1'b1); ser_bit(1'b0); ser_bit(1'b1);
        chk_cfg("R5 latched");

        // R6 transparent serial: load held high while clocking
        ser_load = 1'b1; tick(5);
        {e_t, e_n, e_m} = e_sreg; e_par = 1'b0;
        chk_cfg("R6 open");
        ser_bit(1'b1); chk_cfg("R6 step1");
        ser_bit(1'b0); chk_cfg("R6 step2");
        ser_bit(1'b1); chk_cfg("R6 step3");
        ser_load = 1'b0; tick(5);

        // R7 mux selections
        ser_frame(2'd0, 2'd0, 9'd12);
        mdiv_pulse = 1'b1; half_rate = 1'b1; ser_data = 1'b1; tick(4);
        chk("R7 sel0 low", test_out, 0);
        ser_frame(2'd1, 2'd0, 9'd12);
        ser_data = 1'b1; tick(4); chk("R7 sel1 sdata hi", test_out, 1);
        ser_data = 1'b0; tick(4); chk("R7 sel1 sdata lo", test_out, 0);
        ser_frame(2'd2, 2'd0, 9'd12);
        mdiv_pulse = 1'b1; tick(1); chk("R7 sel2 hi", test_out, 1);
        mdiv_pulse = 1'b0; tick(1); chk("R7 sel2 lo", test_out, 0);
        ser_frame(2'd3, 2'd0, 9'd12);
        half_rate = 1'b1; tick(1); chk("R7 sel3 hi", test_out, 1);
        half_rate = 1'b0; tick(1); chk("R7 sel3 lo", test_out, 0);

        // R8 parallel mode forces low, T retained
        half_rate = 1'b1; tick(1); chk("R8 pre", test_out, 1);
        par_load_n = 1'b0; tick(5); chk("R8 strobe low", test_out, 0);
        par_load_n = 1'b1; tick(5); chk("R8 after latch", test_out, 0);
        chk("R8 t kept", t_bits, 3);
        ser_load = 1'b1; tick(5); ser_load = 1'b0; tick(5);
        e_par = 1'b0; {e_t, e_n, e_m} = e_sreg;
        chk("R8 released", test_out, 1);
        half_rate = 1'b0;

        // R9 range boundaries
        par_load(9'd9, 2'd0);  chk("R9 m=9", m_in_range, 0);
        par_load(9'd10, 2'd0); chk("R9 m=10", m_in_range, 1);
        par_load(9'd28, 2'd0); chk("R9 m=28", m_in_range, 1);
        par_load(9'd29, 2'd0); chk("R9 m=29", m_in_range, 0);

        // Random mix of both paths
        for (int k = 0; k < 40; k++) begin
            logic [8:0] rm;
            rm = 9'($urandom_range(0, 40));
            if ($urandom_range(0, 1) == 0)
                par_load(rm, 2'($urandom));
            else
                ser_frame(2'($urandom), 2'($urandom), rm);
            mdiv_pulse = 1'($urandom); half_rate = 1'($urandom); tick(2);
            chk_cfg("R2/R5/R9 random");
            chk("R7/R8 random test", test_out, e_test(ser_data));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule